// File: doc/BRIEF.md
# Two-Bank Trigger-Configurable Interrupt Controller

This block gathers a vector of interrupt input lines and presents them to a processor through two independent, identically built register banks. The first bank drives an ordinary interrupt request and the second drives a fast interrupt request. In each bank, software chooses for every line whether it is sensed as a level or as an edge, and whether the active sense is high/rising or low/falling. Edge events are held in a sticky latch until software acknowledges them. A per-line enable mask gates what reaches the bank's status word. The bank's request output is raised whenever that status word is nonzero.

Each input passes through a two-flop synchroniser before any level or edge decision is made. Software reaches the registers over a plain synchronous bus. A write strobe with an address and data updates a register on the clock edge. A read strobe with an address returns data combinationally in the same cycle. Bit n of every register belongs to line n.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, every register reads zero, both request outputs are low, and every line is level-sensitive, active-high and masked off.
- R2: Address bit 5 selects the bank (0 = normal, 1 = fast). Bits 4:2 select the register: 0 pending source, 1 enable mask, 2 acknowledge, 3 trigger mode, 4 polarity, 5 status. Mask, mode and polarity read back what was written. Register slots 6 and 7, and any address whose bits 1:0 are nonzero, read zero and ignore writes. Writes to the source and status slots are ignored, and the acknowledge slot reads zero.
- R3: In level mode (mode bit 0), a line's pending bit equals its input XOR its polarity bit. The pending bit reflects an input change two clock edges after the change.
- R4: In edge mode (mode bit 1), polarity 0 latches rising edges and polarity 1 latches falling edges. The latched bit stays set after the input returns to its idle value and is visible three clock edges after the input change.
- R5: Writing the acknowledge register clears the edge latch of every line whose data bit is 1. Lines whose data bit is 0 keep their latch.
- R6: If an acknowledge write and a newly detected edge on the same line fall on the same clock edge, the latch for that line remains set.
- R7: The source register shows pending bits regardless of the mask. The status register equals the source ANDed with the mask.
- R8: Each bank's request output is high exactly when that bank's status register is nonzero.
- R9: The two banks are independent. Configuration or acknowledges in one bank do not change the registers, status or request of the other.
- R10: An acknowledge write has no effect on a level-mode line. The line stays pending while its input is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_LINES | Asynchronous interrupt input lines |
| busRd | input | 1 | Read strobe; read data valid in the same cycle |
| busWr | input | 1 | Write strobe, captured on the clock edge |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | NUM_LINES | Write data, bit n for line n |
| busRdata | output | NUM_LINES | Read data; zero when busRd is low |
| normalReq | output | 1 | Normal-bank interrupt request |
| fastReq | output | 1 | Fast-bank interrupt request |

## Verification
The bench sweeps both banks over several polarity and mask words, in both trigger modes, and derives pending and status values arithmetically from the driven inputs. It times an acknowledge write to land on the exact edge where a new rising edge is latched. A design that gives priority to the clear would lose that interrupt, and the bench would see the line read zero. It acknowledges level lines that are still active, where a design that clears them would drop an asserted request. It also issues partial acknowledges, where a design that treats zero data bits as clears would wipe unrelated latches. Writes to unmapped slots, misaligned addresses and read-only slots are checked for no effect. Each bank is checked for leaks while the other is active, which catches swapped bank decode.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int NUM_BANKS = 2;
  localparam int ADDR_W    = 6;

  typedef enum logic [2:0] {
    REG_SRC  = 3'd0,
    REG_MASK = 3'd1,
    REG_CLR  = 3'd2,
    REG_MODE = 3'd3,
    REG_POL  = 3'd4,
    REG_STAT = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrMask;
    logic wrMode;
    logic wrPol;
    logic wrClr;
  } bankWr_t;

  typedef struct packed {
    bankWr_t [NUM_BANKS-1:0] wr;
    logic                    rdEn;
    logic                    rdBank;
    logic [2:0]              rdReg;
  } ctlStrobes_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       ctl
);

  logic       aligned;
  logic       bankSel;
  logic [2:0] regIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign bankSel = busAddr[5];
  assign regIdx  = busAddr[4:2];

  always_comb begin
    ctl        = '0;
    ctl.rdEn   = busRd && aligned;
    ctl.rdBank = bankSel;
    ctl.rdReg  = regIdx;
    if (busWr && aligned) begin
      case (regIdx)
        REG_MASK: ctl.wr[bankSel].wrMask = 1'b1;
        REG_MODE: ctl.wr[bankSel].wrMode = 1'b1;
        REG_POL:  ctl.wr[bankSel].wrPol  = 1'b1;
        REG_CLR:  ctl.wr[bankSel].wrClr  = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankWr_t              wr,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] syncIn,
  input  logic [NUM_LINES-1:0] prevIn,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] modeQ,
  output logic [NUM_LINES-1:0] polQ,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] statusVec,
  output logic                 req
);

  logic [NUM_LINES-1:0] latchQ;
  logic [NUM_LINES-1:0] riseEv;
  logic [NUM_LINES-1:0] fallEv;
  logic [NUM_LINES-1:0] edgeEv;
  logic [NUM_LINES-1:0] levelAct;
  logic [NUM_LINES-1:0] clrBits;

  assign riseEv   = syncIn & ~prevIn;
  assign fallEv   = ~syncIn & prevIn;
  assign edgeEv   = modeQ & ((polQ & fallEv) | (~polQ & riseEv));
  assign levelAct = syncIn ^ polQ;
  assign clrBits  = wr.wrClr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      modeQ  <= '0;
      polQ   <= '0;
      latchQ <= '0;
    end else begin
      if (wr.wrMask) maskQ <= wdata;
      if (wr.wrMode) modeQ <= wdata;
      if (wr.wrPol)  polQ  <= wdata;
      // new edge wins over a same-cycle acknowledge
      latchQ <= (latchQ & ~clrBits) | edgeEv;
    end
  end

  assign pendVec   = (modeQ & latchQ) | (~modeQ & levelAct);
  assign statusVec = pendVec & maskQ;
  assign req       = |statusVec;

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_LINES-1:0]                 srcIn,
  input  logic [NUM_LINES-1:0]                 busWdata,
  input  ctlStrobes_t                          ctl,
  output logic [NUM_LINES-1:0]                 busRdata,
  output logic [NUM_BANKS-1:0]                 reqVec,
  output logic [NUM_BANKS-1:0][NUM_LINES-1:0]  statusVec,
  output logic [NUM_BANKS-1:0][NUM_LINES-1:0]  maskVec
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_LINES-1:0] syncStage [SYNC_STAGES];
  logic [NUM_LINES-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '0;
      prevQ <= '0;
    end else begin
      syncStage[0] <= srcIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
      prevQ <= syncStage[LAST_STAGE];
    end
  end

  logic [NUM_BANKS-1:0][NUM_LINES-1:0] modeVec;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] polVec;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] pendVec;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    intc_bank #(.NUM_LINES(NUM_LINES)) uBank (
      .clk       (clk),
      .rstN      (rstN),
      .wr        (ctl.wr[g]),
      .wdata     (busWdata),
      .syncIn    (syncStage[LAST_STAGE]),
      .prevIn    (prevQ),
      .maskQ     (maskVec[g]),
      .modeQ     (modeVec[g]),
      .polQ      (polVec[g]),
      .pendVec   (pendVec[g]),
      .statusVec (statusVec[g]),
      .req       (reqVec[g])
    );
  end

  logic [NUM_LINES-1:0] rdSel;

  always_comb begin
    rdSel = '0;
    case (ctl.rdReg)
      REG_SRC:  rdSel = pendVec[ctl.rdBank];
      REG_MASK: rdSel = maskVec[ctl.rdBank];
      REG_MODE: rdSel = modeVec[ctl.rdBank];
      REG_POL:  rdSel = polVec[ctl.rdBank];
      REG_STAT: rdSel = statusVec[ctl.rdBank];
      default:  rdSel = '0;
    endcase
    busRdata = ctl.rdEn ? rdSel : '0;
  end

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] srcIn,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  output logic                 normalReq,
  output logic                 fastReq
);

  ctlStrobes_t                         ctl;
  logic [NUM_BANKS-1:0]                reqVec;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] statusVec;
  logic [NUM_BANKS-1:0][NUM_LINES-1:0] maskVec;

  intc_ctrl uCtrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .ctl     (ctl)
  );

  intc_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .busWdata  (busWdata),
    .ctl       (ctl),
    .busRdata  (busRdata),
    .reqVec    (reqVec),
    .statusVec (statusVec),
    .maskVec   (maskVec)
  );

  assign normalReq = reqVec[0];
  assign fastReq   = reqVec[1];

endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                busRd,
  input logic                                busWr,
  input logic [ADDR_W-1:0]                   busAddr,
  input logic [NUM_LINES-1:0]                busWdata,
  input logic [NUM_LINES-1:0]                busRdata,
  input logic                                normalReq,
  input logic                                fastReq,
  input logic [NUM_BANKS-1:0][NUM_LINES-1:0] statusVec,
  input logic [NUM_BANKS-1:0][NUM_LINES-1:0] maskVec
);

  AST_NORMAL_REQ_IS_OR: assert property (@(posedge clk) disable iff (!rstN)
    normalReq == (statusVec[0] != '0)); // R8
  AST_FAST_REQ_IS_OR: assert property (@(posedge clk) disable iff (!rstN)
    fastReq == (statusVec[1] != '0)); // R8
  AST_STATUS_UNDER_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec[0] & ~maskVec[0]) == '0) && ((statusVec[1] & ~maskVec[1]) == '0)); // R7
  AST_NORMAL_MASK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 6'h04) |=> (maskVec[0] == $past(busWdata))); // R2
  AST_FAST_MASK_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 6'h04) |=> $stable(maskVec[1])); // R9
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busAddr[4:3] == 2'b11 || busAddr[1:0] != 2'b00)) |-> (busRdata == '0)); // R2

endmodule

bind intc_dual_bank intc_checker #(.NUM_LINES(NUM_LINES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busRd     (busRd),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .normalReq (normalReq),
  .fastReq   (fastReq),
  .statusVec (statusVec),
  .maskVec   (maskVec)
);

// File: tb/tb_intc_dual_bank.sv
module tb_intc_dual_bank;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcIn = '0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [5:0]    busAddr = '0;
  logic [N-1:0]  busWdata = '0;
  logic [N-1:0]  busRdata;
  logic          normalReq;
  logic          fastReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intc_dual_bank #(.NUM_LINES(N)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .normalReq(normalReq), .fastReq(fastReq)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [N-1:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [N-1:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] edgesOf(input logic [N-1:0] a, input logic [N-1:0] b,
                                           input logic [N-1:0] p);
    return (~p & ~a & b) | (p & a & ~b);
  endfunction

  function automatic logic reqOf(input int b);
    return (b == 0) ? normalReq : fastReq;
  endfunction

  task automatic cfgBank(input int b, input logic [N-1:0] m, input logic [N-1:0] md,
                         input logic [N-1:0] p);
    logic [5:0] base;
    base = (b == 0) ? 6'h00 : 6'h20;
    wrReg(base + 6'h04, m);
    wrReg(base + 6'h0C, md);
    wrReg(base + 6'h10, p);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);

    // R1: reset state of every slot and both outputs
    for (int a = 0; a < 64; a += 4) begin
      rdReg(a[5:0], d);
      check($sformatf("R1 reset read %0h", a), d, '0);
    end
    check("R1 normalReq reset", {31'b0, normalReq}, '0);
    check("R1 fastReq reset", {31'b0, fastReq}, '0);

    // R2: ignored writes to unmapped, misaligned and read-only slots
    wrReg(6'h18, '1); wrReg(6'h3C, '1); wrReg(6'h05, '1); wrReg(6'h00, '1); wrReg(6'h14, '1);
    rdReg(6'h18, d); check("R2 unmapped 0x18", d, '0);
    rdReg(6'h3C, d); check("R2 unmapped 0x3C", d, '0);
    rdReg(6'h04, d); check("R2 misaligned write ignored", d, '0);
    rdReg(6'h00, d); check("R2 source write ignored", d, '0);
    rdReg(6'h14, d); check("R2 status write ignored", d, '0);

    // R2 and R9: readback per bank, other bank untouched
    for (int b = 0; b < 2; b++) begin
      logic [5:0] base, other;
      base  = (b == 0) ? 6'h00 : 6'h20;
      other = (b == 0) ? 6'h20 : 6'h00;
      for (int r = 1; r < 5; r++) begin
        logic [N-1:0] pat;
        pat = (r * 32'h9E3779B9) ^ (b * 32'h5555AAAA);
        wrReg(base + r * 4, pat);
        rdReg(base + r * 4, d);
        check($sformatf("R2 readback bank%0d reg%0d", b, r), d, (r == 2) ? '0 : pat);
        rdReg(other + r * 4, d);
        check($sformatf("R9 other bank reg%0d", r), d, '0);
      end
      cfgBank(b, '0, '0, '0);
    end

    // R3, R7, R8, R9: level sweep
    for (int b = 0; b < 2; b++) begin
      logic [5:0] base;
      base = (b == 0) ? 6'h00 : 6'h20;
      for (int k = 0; k < 4; k++) begin
        logic [N-1:0] p, m;
        p = k * 32'h6B43A9B5;
        m = 32'h5A5AF00F ^ (k * 32'h01010101);
        cfgBank(b, m, '0, p);
        for (int j = 0; j < 4; j++) begin
          logic [N-1:0] s;
          s = (j == 3) ? p : ((k * 7 + j) * 32'h2545F491);
          srcIn = s;
          settle();
          rdReg(base + 6'h00, d); check("R3 level source", d, s ^ p);
          rdReg(base + 6'h14, d); check("R7 level status", d, (s ^ p) & m);
          check("R8 level request", {31'b0, reqOf(b)}, {31'b0, |((s ^ p) & m)});
          check("R9 idle bank quiet", {31'b0, reqOf(1 - b)}, '0);
        end
        cfgBank(b, '0, '0, '0);
      end
    end

    // R4, R5, R8: edge sweep
    for (int b = 0; b < 2; b++) begin
      logic [5:0] base;
      base = (b == 0) ? 6'h00 : 6'h20;
      for (int k = 0; k < 3; k++) begin
        logic [N-1:0] p, s0, s1, exp, c;
        p  = (k == 0) ? '0 : ((k == 1) ? '1 : 32'h9E3779B9);
        s0 = (k * 32'h3C6EF372) ^ 32'h00000F0F;
        s1 = s0 ^ (32'h13579BDF << k);
        cfgBank(b, '1, '1, p);
        srcIn = s0;
        settle();
        wrReg(base + 6'h08, '1);
        rdReg(base + 6'h00, d); check("R5 edge cleared", d, '0);
        srcIn = s1;
        settle();
        exp = edgesOf(s0, s1, p);
        rdReg(base + 6'h14, d); check("R4 edge latched", d, exp);
        check("R8 edge request", {31'b0, reqOf(b)}, {31'b0, |exp});
        srcIn = s0;
        settle();
        exp = exp | edgesOf(s1, s0, p);
        rdReg(base + 6'h00, d); check("R4 edge sticky", d, exp);
        c = 32'h00FFFF00 ^ s0;
        wrReg(base + 6'h08, c);
        rdReg(base + 6'h00, d); check("R5 partial clear", d, exp & ~c);
        cfgBank(b, '0, '0, '0);
        wrReg(base + 6'h08, '1);
      end
    end

    // R6: acknowledge and new edge on the same clock edge
    srcIn = '0;
    cfgBank(0, '1, '1, '0);
    settle();
    wrReg(6'h08, '1);
    srcIn = 32'h18;
    settle();
    rdReg(6'h00, d); check("R6 pre latch", d, 32'h18);
    srcIn = 32'h10;
    settle();
    @(negedge clk) srcIn = 32'h18;
    @(posedge clk);
    @(posedge clk);
    wrReg(6'h08, 32'h18);
    settle();
    rdReg(6'h00, d); check("R6 edge beats clear", d, 32'h08);
    cfgBank(0, '0, '0, '0);
    srcIn = '0;
    settle();

    // R10: acknowledge ignored on level line
    cfgBank(0, 32'h20, '0, '0);
    srcIn = 32'h20;
    settle();
    wrReg(6'h08, '1);
    rdReg(6'h14, d); check("R10 level survives clear", d, 32'h20);
    check("R10 request stays", {31'b0, normalReq}, 32'h1);
    cfgBank(0, '0, '0, '0);
    srcIn = '0;
    settle();

    // R7: masked edge visible in source only
    cfgBank(1, '0, '1, '0);
    wrReg(6'h28, '1);
    srcIn = 32'h200;
    settle();
    rdReg(6'h20, d); check("R7 masked source", d, 32'h200);
    rdReg(6'h34, d); check("R7 masked status", d, '0);
    check("R7 masked request", {31'b0, fastReq}, '0);
    wrReg(6'h24, 32'h200);
    rdReg(6'h34, d); check("R7 unmasked status", d, 32'h200);
    check("R8 unmasked request", {31'b0, fastReq}, 32'h1);
    check("R9 normal quiet", {31'b0, normalReq}, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule